// File: doc/BRIEF.md
# Sequential Restoring Divider with Remainder and Modulus

This block divides an N-bit dividend by an M-bit divisor over several clock cycles. It produces an N-bit quotient and two M-bit results: a remainder and a modulus. Each operation runs either as unsigned or as two's-complement signed arithmetic, chosen by a mode flag that is sampled together with the operands. Internally a restoring loop retires one quotient bit per clock. Signed operands are first reduced to magnitudes, and the signs are restored after the loop.

The caller waits for `ready`, then raises `start` for one cycle with the operands and the mode. Exactly N+2 clock edges later `done` pulses and the results appear. The results, including a divide-by-zero flag, stay on the outputs until the next operation completes. The remainder follows the sign of the dividend. The modulus follows the sign of the divisor and is zero when the division is exact. A zero divisor does not stall the handshake: it produces defined outputs and raises the flag.

Top module: `seq_divider`

## Requirements
- R1: After reset, `ready` is 1, `done` is 0, and `quotient`, `remainder`, `modulus` and `div_by_zero` are all 0.
- R2: `start` is accepted only on a clock edge where `ready` is 1. `ready` is 0 from the next cycle until `done`. A `start` raised while busy has no effect: the running operation's results are unchanged and no extra `done` follows.
- R3: `done` is high for exactly one cycle, N+2 clock edges after the accepting edge. `ready` is 1 in that same cycle.
- R4: In unsigned mode (`sgn_mode`=0) with a nonzero divisor, `quotient` = floor(dividend/divisor) and `remainder` = dividend − quotient·divisor.
- R5: In unsigned mode `modulus` equals `remainder`.
- R6: In signed mode (`sgn_mode`=1) the quotient is the two's-complement quotient truncated toward zero, taken modulo 2^N. The most-negative dividend divided by −1 therefore gives 2^(N−1).
- R7: In signed mode `remainder` = dividend − quotient·divisor as an M-bit two's-complement value. It is zero or carries the sign of the dividend.
- R8: In signed mode `modulus` is 0 when the remainder is 0. Otherwise it carries the sign of the divisor: it equals remainder + divisor when the signs of remainder and divisor differ, and equals remainder when they agree.
- R9: A divisor of all zeros, in either mode, sets `div_by_zero`=1, sets `quotient` to all ones, and sets both `remainder` and `modulus` to the low M bits of the dividend. Any nonzero divisor gives `div_by_zero`=0.
- R10: `quotient`, `remainder`, `modulus` and `div_by_zero` do not change except in the cycle in which `done` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (taken when `ready`) |
| sgn_mode | input | 1 | 1 = two's-complement signed, 0 = unsigned |
| dividend | input | DVD_W | Dividend operand |
| divisor | input | DVS_W | Divisor operand |
| ready | output | 1 | Idle, able to accept `start` |
| done | output | 1 | One-cycle completion strobe |
| quotient | output | DVD_W | Quotient result |
| remainder | output | DVS_W | Remainder, sign of dividend |
| modulus | output | DVS_W | Modulus, sign of divisor |
| div_by_zero | output | 1 | Divisor was zero for the last result |

## Verification
The state that can go wrong is the partial remainder and the quotient shift register. An error in either one spoils every later quotient bit. It is still invisible until the `done` strobe, N+2 edges after the start, when the quotient or remainder comes out wrong. Mistakes in the sign fix-up show only for particular sign pairs and only in signed mode. A bad loop count moves the `done` strobe and breaks the fixed latency. Every operand pair of a small configuration is therefore checked in both modes, together with the latency of each operation.

// File: rtl/div_pkg.sv
package div_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_COND = 2'd1,
      ST_LOOP = 2'd2,
      ST_FIX  = 2'd3
   } div_state_e;
endpackage

// File: rtl/div_operand_cond.sv
// Converts signed operands to magnitudes; unsigned operands pass through.
module div_operand_cond #(
   parameter int DVD_W = 16,
   parameter int DVS_W = 8
) (
   input  logic             sgn,
   input  logic [DVD_W-1:0] a_in,
   input  logic [DVS_W-1:0] b_in,
   output logic [DVD_W-1:0] a_mag,
   output logic [DVS_W-1:0] b_mag,
   output logic             a_neg,
   output logic             b_neg
);
   assign a_neg = sgn & a_in[DVD_W-1];
   assign b_neg = sgn & b_in[DVS_W-1];
   assign a_mag = a_neg ? (~a_in + 1'b1) : a_in;
   assign b_mag = b_neg ? (~b_in + 1'b1) : b_in;
endmodule

// File: rtl/div_restore_step.sv
// One restoring step: trial subtract via inverted divisor plus carry-in of one.
module div_restore_step #(
   parameter int DVS_W = 8
) (
   input  logic [DVS_W:0]   part_in,
   input  logic [DVS_W-1:0] dvs,
   output logic             qbit,
   output logic [DVS_W:0]   part_out
);
   logic [DVS_W:0]   cy;
   logic [DVS_W-1:0] diff;

   assign cy[0] = 1'b1;
   for (genvar j = 0; j < DVS_W; j++) begin : g_ripple
      logic nb;
      assign nb       = ~dvs[j];
      assign diff[j]  = part_in[j] ^ nb ^ cy[j];
      assign cy[j+1]  = (part_in[j] & nb) | (part_in[j] & cy[j]) | (nb & cy[j]);
   end

   // the extra top bit of the partial remainder joins the final carry
   assign qbit     = cy[DVS_W] | part_in[DVS_W];
   assign part_out = qbit ? {1'b0, diff} : part_in;
endmodule

// File: rtl/div_sign_fix.sv
// Restores signs on quotient, remainder and modulus; handles zero divisor.
module div_sign_fix #(
   parameter int DVD_W = 16,
   parameter int DVS_W = 8
) (
   input  logic [DVD_W-1:0] q_mag,
   input  logic [DVS_W-1:0] r_mag,
   input  logic             a_neg,
   input  logic             b_neg,
   input  logic [DVS_W-1:0] b_raw,
   input  logic [DVS_W-1:0] a_low,
   input  logic             dz,
   output logic [DVD_W-1:0] q_out,
   output logic [DVS_W-1:0] r_out,
   output logic [DVS_W-1:0] m_out
);
   logic [DVS_W-1:0] r_negv;
   assign r_negv = ~r_mag + 1'b1;

   always_comb begin
      if (dz) begin
         q_out = '1;
         r_out = a_low;
         m_out = a_low;
      end else begin
         q_out = (a_neg ^ b_neg) ? (~q_mag + 1'b1) : q_mag;
         r_out = a_neg ? r_negv : r_mag;
         if (r_mag == '0) begin
            m_out = '0;
         end else begin
            unique case ({b_neg, a_neg})
               2'b11:   m_out = r_negv;
               2'b10:   m_out = b_raw + r_mag;
               2'b01:   m_out = b_raw - r_mag;
               default: m_out = r_mag;
            endcase
         end
      end
   end
endmodule

// File: rtl/seq_divider.sv
module seq_divider #(
   parameter int DVD_W = 16,
   parameter int DVS_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             sgn_mode,
   input  logic [DVD_W-1:0] dividend,
   input  logic [DVS_W-1:0] divisor,
   output logic             ready,
   output logic             done,
   output logic [DVD_W-1:0] quotient,
   output logic [DVS_W-1:0] remainder,
   output logic [DVS_W-1:0] modulus,
   output logic             div_by_zero
);
   import div_pkg::*;

   localparam int CNT_W = $clog2(DVD_W + 1);
   localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(DVD_W - 1);

   if (DVS_W < 2) begin : g_bad_dvs
      $error("seq_divider: DVS_W must be at least 2");
   end
   if (DVD_W < DVS_W) begin : g_bad_dvd
      $error("seq_divider: DVD_W must not be below DVS_W");
   end

   div_state_e       st;
   logic [DVD_W-1:0] raw_a;
   logic [DVS_W-1:0] raw_b;
   logic             sgn_r;
   logic             a_neg_r, b_neg_r;
   logic [DVS_W-1:0] b_mag_r;
   logic [DVD_W-1:0] shq;
   logic [DVS_W:0]   part;
   logic [CNT_W-1:0] cnt;

   logic [DVD_W-1:0] c_a_mag;
   logic [DVS_W-1:0] c_b_mag;
   logic             c_a_neg, c_b_neg;
   logic             s_qbit;
   logic [DVS_W:0]   s_next;
   logic [DVD_W-1:0] f_q;
   logic [DVS_W-1:0] f_r, f_m;
   logic             dvs_zero;

   div_operand_cond #(.DVD_W(DVD_W), .DVS_W(DVS_W)) u_cond (
      .sgn   (sgn_r),
      .a_in  (raw_a),
      .b_in  (raw_b),
      .a_mag (c_a_mag),
      .b_mag (c_b_mag),
      .a_neg (c_a_neg),
      .b_neg (c_b_neg)
   );

   div_restore_step #(.DVS_W(DVS_W)) u_step (
      .part_in  ({part[DVS_W-1:0], shq[DVD_W-1]}),
      .dvs      (b_mag_r),
      .qbit     (s_qbit),
      .part_out (s_next)
   );

   assign dvs_zero = (raw_b == '0);

   div_sign_fix #(.DVD_W(DVD_W), .DVS_W(DVS_W)) u_fix (
      .q_mag (shq),
      .r_mag (part[DVS_W-1:0]),
      .a_neg (a_neg_r),
      .b_neg (b_neg_r),
      .b_raw (raw_b),
      .a_low (raw_a[DVS_W-1:0]),
      .dz    (dvs_zero),
      .q_out (f_q),
      .r_out (f_r),
      .m_out (f_m)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= ST_IDLE;
         raw_a       <= '0;
         raw_b       <= '0;
         sgn_r       <= 1'b0;
         a_neg_r     <= 1'b0;
         b_neg_r     <= 1'b0;
         b_mag_r     <= '0;
         shq         <= '0;
         part        <= '0;
         cnt         <= '0;
         done        <= 1'b0;
         quotient    <= '0;
         remainder   <= '0;
         modulus     <= '0;
         div_by_zero <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (st)
            ST_IDLE: begin
               if (start) begin
                  raw_a <= dividend;
                  raw_b <= divisor;
                  sgn_r <= sgn_mode;
                  st    <= ST_COND;
               end
            end
            ST_COND: begin
               shq     <= c_a_mag;
               b_mag_r <= c_b_mag;
               a_neg_r <= c_a_neg;
               b_neg_r <= c_b_neg;
               part    <= '0;
               cnt     <= LAST_STEP;
               st      <= ST_LOOP;
            end
            ST_LOOP: begin
               part <= s_next;
               shq  <= {shq[DVD_W-2:0], s_qbit};
               if (cnt == '0) st <= ST_FIX;
               else           cnt <= cnt - 1'b1;
            end
            ST_FIX: begin
               quotient    <= f_q;
               remainder   <= f_r;
               modulus     <= f_m;
               div_by_zero <= dvs_zero;
               done        <= 1'b1;
               st          <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign ready = (st == ST_IDLE);
endmodule

// File: rtl/div_checker.sv
module div_checker #(
   parameter int DVD_W = 16,
   parameter int DVS_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             sgn_mode,
   input logic [DVD_W-1:0] dividend,
   input logic [DVS_W-1:0] divisor,
   input logic             ready,
   input logic             done,
   input logic [DVD_W-1:0] quotient,
   input logic [DVS_W-1:0] remainder,
   input logic [DVS_W-1:0] modulus,
   input logic             div_by_zero
);
   localparam int LW = $clog2(DVD_W + 4) + 1;
   localparam int PW = DVD_W + DVS_W + 1;

   logic             busy;
   logic [LW-1:0]    lat;
   logic [DVD_W-1:0] a_l;
   logic [DVS_W-1:0] b_l;
   logic             m_l;
   logic [PW-1:0]    recon;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         lat  <= '0;
         a_l  <= '0;
         b_l  <= '0;
         m_l  <= 1'b0;
      end else if (start && ready) begin
         busy <= 1'b1;
         lat  <= '0;
         a_l  <= dividend;
         b_l  <= divisor;
         m_l  <= sgn_mode;
      end else if (done) begin
         busy <= 1'b0;
      end else if (busy) begin
         lat <= lat + 1'b1;
      end
   end

   assign recon = PW'(quotient) * PW'(b_l) + PW'(remainder);

   a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r3_ready_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ready);
   a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (busy && lat == LW'(DVD_W + 2)));
   a_r2_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
      (start && ready) |=> !ready);
   a_r4_identity: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !m_l && b_l != '0) |-> (recon == PW'(a_l) && remainder < b_l));
   a_r5_mod_eq_rem: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !m_l) |-> (modulus == remainder));
   a_r9_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (div_by_zero == (b_l == '0)));
   a_r9_zero_quot: assert property (@(posedge clk) disable iff (!rst_n)
      (done && b_l == '0) |-> (quotient == '1 && remainder == a_l[DVS_W-1:0]));
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !done |=> ($stable(quotient) || done));
endmodule

bind seq_divider div_checker #(.DVD_W(DVD_W), .DVS_W(DVS_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start       (start),
   .sgn_mode    (sgn_mode),
   .dividend    (dividend),
   .divisor     (divisor),
   .ready       (ready),
   .done        (done),
   .quotient    (quotient),
   .remainder   (remainder),
   .modulus     (modulus),
   .div_by_zero (div_by_zero)
);

// File: tb/sim_seq_divider.sv
module sim_seq_divider;
   localparam int N = 6;
   localparam int M = 4;
   localparam int QMASK = (1 << N) - 1;
   localparam int RMASK = (1 << M) - 1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic         sgn_mode = 1'b0;
   logic [N-1:0] dividend = '0;
   logic [M-1:0] divisor = '0;
   logic         ready, done, div_by_zero;
   logic [N-1:0] quotient;
   logic [M-1:0] remainder, modulus;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   seq_divider #(.DVD_W(N), .DVS_W(M)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .sgn_mode(sgn_mode),
      .dividend(dividend), .divisor(divisor), .ready(ready), .done(done),
      .quotient(quotient), .remainder(remainder), .modulus(modulus),
      .div_by_zero(div_by_zero)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic expect_vals(input int a, input int b, input bit s,
                              output int eq, output int er, output int em, output int ez);
      int sa, sb, qi, ri;
      if (b == 0) begin
         eq = QMASK; er = a & RMASK; em = a & RMASK; ez = 1;
      end else if (!s) begin
         eq = a / b; er = a % b; em = er; ez = 0;
      end else begin
         sa = (a >= (1 << (N-1))) ? a - (1 << N) : a;
         sb = (b >= (1 << (M-1))) ? b - (1 << M) : b;
         qi = sa / sb;
         ri = sa % sb;
         eq = qi & QMASK;
         er = ri & RMASK;
         if (ri == 0) em = 0;
         else if ((ri < 0) != (sb < 0)) em = (ri + sb) & RMASK;
         else em = ri & RMASK;
         ez = 0;
      end
   endtask

   // Runs one operation; optional busy-time start with other operands.
   task automatic run_op(input int a, input int b, input bit s, input bit poke, output int lat);
      int k;
      while (!ready) @(negedge clk);
      start = 1'b1; sgn_mode = s;
      dividend = N'(a); divisor = M'(b);
      @(negedge clk);
      start = 1'b0;
      k = 1;
      while (!done && k < 40) begin
         if (poke && k == 3) begin
            start = 1'b1; sgn_mode = ~s;
            dividend = N'(a ^ 21); divisor = M'(b ^ 5);
         end
         @(negedge clk);
         start = 1'b0;
         k++;
      end
      lat = k;
   endtask

   task automatic verify(input int a, input int b, input bit s, input string tag);
      int eq, er, em, ez;
      expect_vals(a, b, s, eq, er, em, ez);
      check(int'(quotient) == eq, {tag, " quotient"}, int'(quotient), eq);
      check(int'(remainder) == er, {tag, " remainder"}, int'(remainder), er);
      check(int'(modulus) == em, {tag, " modulus"}, int'(modulus), em);
      check(int'(div_by_zero) == ez, {tag, " div_by_zero"}, int'(div_by_zero), ez);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      int lat;
      repeat (3) @(negedge clk);
      // R1: reset state
      check(ready == 1'b1 && done == 1'b0, "R1 handshake", {ready, done}, 2);
      check(quotient == '0 && remainder == '0 && modulus == '0 && div_by_zero == 1'b0,
            "R1 outputs", int'(quotient), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3: fixed latency and single-cycle strobe
      run_op(45, 7, 1'b0, 1'b0, lat);
      check(lat == N + 3, "R3 latency", lat, N + 3);
      check(ready == 1'b1, "R3 ready with done", ready, 1);
      @(negedge clk);
      check(done == 1'b0, "R3 one-cycle done", done, 0);

      // R10: outputs held between strobes
      repeat (5) @(negedge clk);
      verify(45, 7, 1'b0, "R10 hold");

      // R2: start while busy is ignored
      run_op(50, 3, 1'b0, 1'b1, lat);
      check(lat == N + 3, "R2 latency with busy start", lat, N + 3);
      verify(50, 3, 1'b0, "R2 busy start ignored");
      for (int i = 0; i < N + 5; i++) begin
         @(negedge clk);
         check(done == 1'b0, "R2 no extra done", done, 0);
      end

      // R4 R5 R9: exhaustive unsigned
      for (int a = 0; a < (1 << N); a++)
         for (int b = 0; b < (1 << M); b++) begin
            run_op(a, b, 1'b0, 1'b0, lat);
            check(lat == N + 3, "R3 latency sweep", lat, N + 3);
            verify(a, b, 1'b0, (b == 0) ? "R9 unsigned" : "R4 R5 unsigned");
         end

      // R6 R7 R8 R9: exhaustive signed (includes most-negative / -1)
      for (int a = 0; a < (1 << N); a++)
         for (int b = 0; b < (1 << M); b++) begin
            run_op(a, b, 1'b1, 1'b0, lat);
            verify(a, b, 1'b1, (b == 0) ? "R9 signed" : "R6 R7 R8 signed");
         end

      // R6: explicit wrap corner, -32 / -1
      run_op(32, 15, 1'b1, 1'b0, lat);
      check(int'(quotient) == 32, "R6 wrap corner", int'(quotient), 32);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule